// File: doc/BRIEF.md
# Bridge Fault Retry Supervisor

This block watches the fault flags of a dual full-bridge output stage and decides when every switch of the bridge must be forced off. Each of the eight output switches reports its own overcurrent flag. A junction over-temperature comparator reports two flags: a trip flag and a separate clear flag, which models the hysteresis band. All timing runs on a one-microsecond tick strobe that the clock domain supplies. The block does not latch a fault. It forces a fixed off interval and then re-enables the bridge by itself. If the fault is still present, the whole sequence runs again.

An overcurrent counts only when at least one flag has stayed high for a programmable number of ticks. A shorter burst is discarded, and the next burst starts its count from zero. The shutdown output rises in the same cycle that the qualification count completes. A thermal trip acts at once. After its off interval, the bridge re-enables only if the clear flag has been seen with the trip flag low. Sticky status bits record which fault kind occurred and which switches were flagged at the moment of an overcurrent shutdown. A clear strobe erases them.

All pins are plain level or strobe control signals, so there is no streaming handshake at the block's edge.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: After reset, `out_disable`, `stat_oc`, `stat_therm` and `oc_src` are all 0.
- R2: An overcurrent on any single one of the `NUM_SW` flags is enough to shut down the whole bridge through the one `out_disable` pin.
- R3: While the bridge is enabled and at least one overcurrent flag is high in consecutive ticked cycles, `out_disable` goes to 1 combinationally in the cycle of the `QUAL_US`-th such tick.
- R4: If all overcurrent flags drop before qualification completes, no shutdown occurs, and a later burst must again last `QUAL_US` ticks.
- R5: Both the qualification count and the off-interval count advance only in cycles where `us_tick` is 1. Cycles without a tick neither advance nor reset either count.
- R6: After a shutdown, `out_disable` stays 1 for the cycles that contain the next `OFF_US` ticks. With no pending thermal condition, it returns to 0 in the cycle after the last of those ticks.
- R7: If overcurrent persists after re-enable, qualification restarts from zero and the trip, off and re-enable sequence repeats without limit.
- R8: A high `therm_trip` while enabled sets `out_disable` to 1 in the same cycle and starts the same off interval.
- R9: A thermal condition is pending from any cycle with `therm_trip`=1 until a cycle with `therm_clear`=1 and `therm_trip`=0. If it is still pending when the off interval ends, the bridge stays disabled until such a clear cycle, and re-enables in the following cycle.
- R10: In the cycle after a shutdown, `stat_oc` or `stat_therm` is 1 according to the cause. `oc_src` gains the flag pattern present in the overcurrent trip cycle, where bit i corresponds to flag i.
- R11: A `status_clr` pulse clears all sticky status from the next cycle. A fault recorded in the same cycle as the pulse takes precedence and stays set.
- R12: Overcurrent flags seen while disabled, during the off interval or while waiting for the thermal clear, neither extend the disabled time nor set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle strobe per microsecond time base |
| oc_flags | input | NUM_SW | Per-switch overcurrent flags, bit i = switch i |
| therm_trip | input | 1 | Over-temperature trip flag |
| therm_clear | input | 1 | Temperature back below the hysteresis threshold |
| status_clr | input | 1 | Strobe that clears the sticky status |
| out_disable | output | 1 | 1 forces every bridge switch off |
| stat_oc | output | 1 | Sticky: an overcurrent shutdown occurred |
| stat_therm | output | 1 | Sticky: a thermal shutdown occurred |
| oc_src | output | NUM_SW | Sticky OR of the flag patterns at overcurrent trips |

## Verification
Overcurrent stimulus comes in several forms. Bursts one tick short of the limit, separated by a quiet cycle, show that the count restarts rather than accumulating. Flags on different switch positions show that any one switch trips the whole bridge and is recorded in its own `oc_src` bit. A flag held on continuously exposes the repeating retry rhythm and shows that the off interval does not stretch. Stretches without ticks, placed both in the qualification phase and in the off phase, separate tick-counted timing from cycle-counted timing. Thermal patterns differ in when the clear flag arrives: during the off interval, after it, or while the trip flag is still high. Together they separate a plain timed retry from the hysteresis hold.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_OFF  = 2'd1,
    ST_HOLD = 2'd2
  } bfs_state_e;
endpackage

// File: rtl/bfs_tick_counter.sv
// Counts tick strobes while enabled; done pulses combinationally on the
// LIMIT-th tick. Disabling clears the count.
module bfs_tick_counter #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic done
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = en && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || done) cnt <= '0;
    else if (tick)       cnt <= cnt + 1'b1;
  end

  // R5: a cycle without a tick leaves the count untouched
  p_hold_without_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));

  // R4: a count is never carried across a gap in enable
  p_gap_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/bfs_status.sv
// Sticky fault record; a new fault wins over a coincident clear.
module bfs_status #(
  parameter int unsigned NUM_SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_trip,
  input  logic              th_trip,
  input  logic [NUM_SW-1:0] flags,
  input  logic              clr,
  output logic              stat_oc,
  output logic              stat_therm,
  output logic [NUM_SW-1:0] oc_src
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_oc    <= 1'b0;
      stat_therm <= 1'b0;
      oc_src     <= '0;
    end else begin
      stat_oc    <= oc_trip | (stat_oc & ~clr);
      stat_therm <= th_trip | (stat_therm & ~clr);
      oc_src     <= (oc_trip ? flags : '0) | (clr ? '0 : oc_src);
    end
  end

  // R10: status is sticky without a clear
  p_oc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_oc && !clr) |=> stat_oc);

  // R11: a fault in the clear cycle still records
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (th_trip && clr) |=> stat_therm);
endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor #(
  parameter int unsigned NUM_SW = 8,
  parameter int unsigned QUAL_US = 10,
  parameter int unsigned OFF_US  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic [NUM_SW-1:0] oc_flags,
  input  logic              therm_trip,
  input  logic              therm_clear,
  input  logic              status_clr,
  output logic              out_disable,
  output logic              stat_oc,
  output logic              stat_therm,
  output logic [NUM_SW-1:0] oc_src
);
  import bfs_pkg::*;

  bfs_state_e state, state_nx;
  logic oc_any, qual_done, off_done;
  logic oc_trip, th_trip, trip;
  logic pend, pend_nx, cool_ok;

  assign oc_any  = |oc_flags;
  assign oc_trip = (state == ST_RUN) && qual_done;
  assign th_trip = (state == ST_RUN) && therm_trip;
  assign trip    = oc_trip || th_trip;
  assign cool_ok = therm_clear && !therm_trip;
  assign pend_nx = therm_trip || (pend && !therm_clear);

  assign out_disable = (state != ST_RUN) || trip;

  bfs_tick_counter #(.LIMIT(QUAL_US)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .en   ((state == ST_RUN) && oc_any),
    .tick (us_tick),
    .done (qual_done)
  );

  bfs_tick_counter #(.LIMIT(OFF_US)) u_off (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state == ST_OFF),
    .tick (us_tick),
    .done (off_done)
  );

  bfs_status #(.NUM_SW(NUM_SW)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .oc_trip   (oc_trip),
    .th_trip   (th_trip),
    .flags     (oc_flags),
    .clr       (status_clr),
    .stat_oc   (stat_oc),
    .stat_therm(stat_therm),
    .oc_src    (oc_src)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:  if (trip) state_nx = ST_OFF;
      ST_OFF:  if (off_done) state_nx = pend_nx ? ST_HOLD : ST_RUN;
      ST_HOLD: if (cool_ok) state_nx = ST_RUN;
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      pend  <= 1'b0;
    end else begin
      state <= state_nx;
      pend  <= pend_nx;
    end
  end

  // R6: a shutdown while enabled always starts the off interval
  p_trip_to_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && out_disable) |=> (state == ST_OFF));

  // R9: waiting for cool-down lasts until a clean clear
  p_hold_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !therm_clear) |=> (state == ST_HOLD && out_disable));

  // R9: a pending thermal condition diverts the end of the off interval
  p_pending_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && off_done && therm_trip) |=> (state == ST_HOLD));

  // R7: re-enable only comes out of the off or hold phase
  p_reenable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_disable) |-> ($past(state) != ST_RUN));

  // R12: disabled phases never record a new fault
  p_no_status_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && !stat_oc) |=> !stat_oc);
endmodule

// File: tb/bridge_fault_supervisor_bench.sv
module bridge_fault_supervisor_bench;
  localparam int NSW = 8;
  localparam int QU  = 4;
  localparam int OU  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic [NSW-1:0] oc_flags = '0;
  logic therm_trip = 1'b0, therm_clear = 1'b0, status_clr = 1'b0;
  logic out_disable, stat_oc, stat_therm;
  logic [NSW-1:0] oc_src;

  always #10 clk = ~clk;

  bridge_fault_supervisor #(.NUM_SW(NSW), .QUAL_US(QU), .OFF_US(OU)) u_bridge_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .oc_flags(oc_flags),
    .therm_trip(therm_trip), .therm_clear(therm_clear), .status_clr(status_clr),
    .out_disable(out_disable), .stat_oc(stat_oc), .stat_therm(stat_therm), .oc_src(oc_src)
  );

  typedef struct {
    string          req;
    logic           dis;
    bit             chk;
    logic           soc;
    logic           sth;
    logic [NSW-1:0] src;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  bit st_chk = 0;
  logic st_oc = 0, st_th = 0;
  logic [NSW-1:0] st_src = '0;

  task automatic stat_next(input logic soc, input logic sth, input logic [NSW-1:0] src);
    st_chk = 1; st_oc = soc; st_th = sth; st_src = src;
  endtask

  // driver: apply one cycle of stimulus and queue what it must produce
  task automatic step(input logic [NSW-1:0] oc, input logic tr, input logic cl,
                      input logic sc, input logic tk, input logic dis, input string req);
    exp_t e;
    @(posedge clk); #1;
    oc_flags = oc; therm_trip = tr; therm_clear = cl; status_clr = sc; us_tick = tk;
    e.req = req; e.dis = dis; e.chk = st_chk; e.soc = st_oc; e.sth = st_th; e.src = st_src;
    st_chk = 0;
    q.push_back(e);
  endtask

  task automatic ocs(input logic [NSW-1:0] oc, input logic dis, input string req);
    step(oc, 0, 0, 0, 1, dis, req);
  endtask

  task automatic rep(input int n, input logic [NSW-1:0] oc, input logic dis, input string req);
    for (int i = 0; i < n; i++) ocs(oc, dis, req);
  endtask

  // monitor: pop and compare once per cycle, away from the clock edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (out_disable !== e.dis) begin
        fails++;
        $display("FAIL %s: out_disable got %0b exp %0b", e.req, out_disable, e.dis);
      end
      if (e.chk) begin
        checks++;
        if (stat_oc !== e.soc || stat_therm !== e.sth || oc_src !== e.src) begin
          fails++;
          $display("FAIL %s: status got oc=%0b th=%0b src=%h exp oc=%0b th=%0b src=%h",
                   e.req, stat_oc, stat_therm, oc_src, e.soc, e.sth, e.src);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state
    #1;
    checks++;
    if (out_disable !== 0 || stat_oc !== 0 || stat_therm !== 0 || oc_src !== 0) begin
      fails++;
      $display("FAIL R1: got dis=%0b oc=%0b th=%0b src=%h exp all zero",
               out_disable, stat_oc, stat_therm, oc_src);
    end
    rst_n = 1'b1;
    rep(2, 8'h00, 0, "R1");

    // R4: bursts one tick short never trip, count restarts
    rep(3, 8'h01, 0, "R4");
    ocs(8'h00, 0, "R4");
    rep(3, 8'h01, 0, "R4");
    stat_next(0, 0, 8'h00);
    ocs(8'h00, 0, "R4");

    // R2 R3: single flag on switch 5 trips in the QU-th tick
    rep(3, 8'h20, 0, "R3");
    ocs(8'h20, 1, "R3");
    // R6 R10: off interval and status
    stat_next(1, 0, 8'h20);
    rep(OU, 8'h00, 1, "R6");
    ocs(8'h00, 0, "R6");

    // R11: clear strobe
    step(8'h00, 0, 0, 1, 1, 0, "R11");
    stat_next(0, 0, 8'h00);
    ocs(8'h00, 0, "R11");

    // R7 R12: persistent flag on switch 7 repeats, off not stretched
    rep(3, 8'h80, 0, "R7");
    ocs(8'h80, 1, "R7");
    rep(OU, 8'h80, 1, "R12");
    rep(3, 8'h80, 0, "R7");
    ocs(8'h80, 1, "R7");
    rep(OU, 8'h80, 1, "R12");
    stat_next(1, 0, 8'h80);
    ocs(8'h00, 0, "R7");
    step(8'h00, 0, 0, 1, 1, 0, "R11");

    // R5: no ticks means no progress in qualification or off interval
    for (int i = 0; i < 5; i++) step(8'h02, 0, 0, 0, 0, 0, "R5");
    rep(3, 8'h02, 0, "R5");
    ocs(8'h02, 1, "R5");
    for (int i = 0; i < 3; i++) step(8'h00, 0, 0, 0, 0, 1, "R5");
    rep(OU, 8'h00, 1, "R5");
    ocs(8'h00, 0, "R5");
    step(8'h00, 0, 0, 1, 1, 0, "R11");

    // R8 R9: thermal trip, clear seen during off interval
    step(8'h00, 1, 0, 0, 1, 1, "R8");
    stat_next(0, 1, 8'h00);
    step(8'h00, 0, 0, 0, 1, 1, "R8");
    step(8'h00, 0, 1, 0, 1, 1, "R9");
    rep(OU - 2, 8'h00, 1, "R9");
    ocs(8'h00, 0, "R9");

    // R9: no clear during off, hold until clear
    step(8'h00, 0, 0, 1, 1, 0, "R11");
    step(8'h00, 1, 0, 0, 1, 1, "R8");
    rep(OU, 8'h00, 1, "R9");
    rep(3, 8'h00, 1, "R9");
    step(8'h00, 0, 1, 0, 1, 1, "R9");
    ocs(8'h00, 0, "R9");

    // R11: fault recorded in the clear cycle wins
    step(8'h00, 0, 0, 1, 1, 0, "R11");
    rep(3, 8'h01, 0, "R11");
    step(8'h01, 0, 0, 1, 1, 1, "R11");
    stat_next(1, 0, 8'h01);
    rep(OU, 8'h00, 1, "R11");
    ocs(8'h00, 0, "R11");

    // R9 R12: trip held past off interval, overcurrent in hold ignored
    step(8'h00, 1, 0, 1, 1, 1, "R8");
    for (int i = 0; i < OU + 1; i++) step(8'h00, 1, 0, 0, 1, 1, "R9");
    rep(5, 8'hFF, 1, "R12");
    step(8'h00, 0, 1, 0, 1, 1, "R9");
    stat_next(0, 1, 8'h00);
    ocs(8'h00, 0, "R12");

    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule